// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the hard-wired controller of a multi-cycle processor datapath. The datapath has one shared ALU and holds each instruction in internal registers: an instruction register, two operand latches, an ALU result latch and a memory data latch. The controller watches the opcode held in the instruction register and the equality flag from the ALU. From these it drives, one cycle at a time, every enable and select the datapath needs: program counter load, instruction register load, memory read and write, register file write, the two ALU operand selects, the ALU operation class, the destination register select, the write-back source select and the program counter source.

Each instruction starts with a fetch cycle and then a decode cycle. In the decode cycle the operand registers are read, and the ALU is idle, so it forms the branch target speculatively. The instruction class chosen in decode then sets how long the instruction runs. A branch ends in 3 cycles. Register, OR-immediate and store instructions take 4 cycles. A load takes 5. Opcodes the controller does not know end right after decode with nothing written. The class is held in the state register, so the opcode is read only during decode.

Top module: `mcCtlTop`

## Requirements
- R1: While rstN is 0, pcWrite, irWrite, memRead, memWrite and regWrite are all 0. The first cycle after rstN rises is a fetch cycle.
- R2: Fetch cycle: pcWrite=1, irWrite=1, memRead=1, iorD=0 (address from PC), aluSrcA=0 (PC), aluSrcB=1 (constant 4), aluOp=0 (add), pcSource=0 (ALU result). The cycle after fetch is always decode.
- R3: Decode cycle: no write strobe is asserted. aluSrcA=0, aluSrcB=3 (sign-extended offset shifted left by 2), aluOp=0. The decode cycle chooses the class from opcode.
- R4: Register-type (opcode 0) runs 4 cycles. Execute: aluSrcA=1 (operand A), aluSrcB=0 (operand B), aluOp=2 (from function field). Write-back: regWrite=1, regDst=1 (rd), memToReg=0.
- R5: OR-immediate (opcode 13) runs 4 cycles. Execute: aluSrcA=1, aluSrcB=4 (zero-extended immediate), aluOp=3 (OR). Write-back: regWrite=1, regDst=0 (rt), memToReg=0.
- R6: Load (opcode 35) runs 5 cycles. Address step: aluSrcA=1, aluSrcB=2 (sign-extended immediate), aluOp=0. Memory step: memRead=1, iorD=1. Write-back: regWrite=1, regDst=0, memToReg=1.
- R7: Store (opcode 43) runs 4 cycles. The address step is the same as for load. Memory step: memWrite=1, iorD=1, with no register write.
- R8: Branch-equal (opcode 4) runs 3 cycles. Execute: aluSrcA=1, aluSrcB=0, aluOp=1 (subtract), pcSource=1 (ALU result latch). pcWrite equals equalFlag in that cycle.
- R9: Any other opcode returns to fetch right after decode (2 cycles) with no write strobe.
- R10: A change of opcode after the decode cycle does not alter the remaining sequence.
- R11: Outside fetch and branch execute, pcWrite is 0 for any equalFlag. memRead and memWrite are never 1 together. Every select not listed for a cycle above is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode field of the instruction register |
| equalFlag | input | 1 | ALU result equals zero |
| pcWrite | output | 1 | Load program counter |
| irWrite | output | 1 | Load instruction register |
| memRead | output | 1 | Memory read |
| memWrite | output | 1 | Memory write |
| iorD | output | 1 | Memory address: 0 PC, 1 ALU result latch |
| regWrite | output | 1 | Register file write |
| regDst | output | 1 | Destination: 0 rt, 1 rd |
| memToReg | output | 1 | Write data: 0 ALU result latch, 1 memory data latch |
| aluSrcA | output | 1 | ALU A input: 0 PC, 1 operand A |
| aluSrcB | output | 3 | ALU B input: 0 B, 1 four, 2 sign-ext, 3 sign-ext shifted, 4 zero-ext |
| aluOp | output | 2 | 0 add, 1 subtract, 2 function field, 3 OR |
| pcSource | output | 1 | PC source: 0 ALU result, 1 ALU result latch |

## Verification
The bench builds the block with its default 6-bit opcode field and the default opcode values. With those defaults, every one of the 64 opcodes can be run, each with the equality flag both low and high. For each instruction the bench checks the full strobe vector of every cycle and the cycle count, so each class and the idle path for unknown opcodes are covered. It also holds the reset low and checks the strobes, and it swaps the opcode after decode to confirm the chosen sequence is kept.

// File: rtl/mcCtlPkg.sv
package mcCtlPkg;
  parameter int OPC_W   = 6;
  parameter int SRCB_W  = 3;
  parameter int ALUOP_W = 2;

  localparam logic [SRCB_W-1:0] SRCB_REG    = SRCB_W'(0);
  localparam logic [SRCB_W-1:0] SRCB_FOUR   = SRCB_W'(1);
  localparam logic [SRCB_W-1:0] SRCB_SEXT   = SRCB_W'(2);
  localparam logic [SRCB_W-1:0] SRCB_BRANCH = SRCB_W'(3);
  localparam logic [SRCB_W-1:0] SRCB_ZEXT   = SRCB_W'(4);

  localparam logic [ALUOP_W-1:0] ALUOP_ADD   = ALUOP_W'(0);
  localparam logic [ALUOP_W-1:0] ALUOP_SUB   = ALUOP_W'(1);
  localparam logic [ALUOP_W-1:0] ALUOP_FUNCT = ALUOP_W'(2);
  localparam logic [ALUOP_W-1:0] ALUOP_OR    = ALUOP_W'(3);

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE,
    ST_LDADR, ST_LDMEM, ST_LDWB,
    ST_STADR, ST_STMEM,
    ST_REXE, ST_RWB,
    ST_OREXE, ST_ORWB,
    ST_BREXE
  } ctlState_e;

  typedef struct packed {
    logic                pcWriteUncond;
    logic                pcWriteCond;
    logic                irWrite;
    logic                memRead;
    logic                memWrite;
    logic                iorD;
    logic                regWrite;
    logic                regDst;
    logic                memToReg;
    logic                aluSrcA;
    logic [SRCB_W-1:0]   aluSrcB;
    logic [ALUOP_W-1:0]  aluOp;
    logic                pcSource;
  } ctlStrobes_t;
endpackage

// File: rtl/mcCtlSequencer.sv
module mcCtlSequencer
  import mcCtlPkg::*;
#(
  parameter logic [OPC_W-1:0] OPC_RTYPE = OPC_W'(0),
  parameter logic [OPC_W-1:0] OPC_ORI   = OPC_W'(13),
  parameter logic [OPC_W-1:0] OPC_LOAD  = OPC_W'(35),
  parameter logic [OPC_W-1:0] OPC_STORE = OPC_W'(43),
  parameter logic [OPC_W-1:0] OPC_BEQ   = OPC_W'(4)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OPC_W-1:0] opcode,
  output ctlState_e        state
);
  ctlState_e nextState;

  // class is only chosen in decode; later states carry it (R10)
  always_comb begin
    nextState = ST_FETCH;
    unique case (state)
      ST_FETCH:  nextState = ST_DECODE;
      ST_DECODE: begin
        if      (opcode == OPC_RTYPE) nextState = ST_REXE;
        else if (opcode == OPC_ORI)   nextState = ST_OREXE;
        else if (opcode == OPC_LOAD)  nextState = ST_LDADR;
        else if (opcode == OPC_STORE) nextState = ST_STADR;
        else if (opcode == OPC_BEQ)   nextState = ST_BREXE;
        else                          nextState = ST_FETCH;
      end
      ST_LDADR:  nextState = ST_LDMEM;
      ST_LDMEM:  nextState = ST_LDWB;
      ST_STADR:  nextState = ST_STMEM;
      ST_REXE:   nextState = ST_RWB;
      ST_OREXE:  nextState = ST_ORWB;
      default:   nextState = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_FETCH;
    else       state <= nextState;
  end
endmodule

// File: rtl/mcCtlStrobeGen.sv
module mcCtlStrobeGen
  import mcCtlPkg::*;
(
  input  ctlState_e   state,
  output ctlStrobes_t strobes
);
  always_comb begin
    strobes         = '0;
    strobes.aluSrcB = SRCB_REG;
    strobes.aluOp   = ALUOP_ADD;
    unique case (state)
      ST_FETCH: begin
        strobes.pcWriteUncond = 1'b1;
        strobes.irWrite       = 1'b1;
        strobes.memRead       = 1'b1;
        strobes.aluSrcB       = SRCB_FOUR;
      end
      ST_DECODE: strobes.aluSrcB = SRCB_BRANCH;
      ST_LDADR, ST_STADR: begin
        strobes.aluSrcA = 1'b1;
        strobes.aluSrcB = SRCB_SEXT;
      end
      ST_LDMEM: begin
        strobes.memRead = 1'b1;
        strobes.iorD    = 1'b1;
      end
      ST_LDWB: begin
        strobes.regWrite = 1'b1;
        strobes.memToReg = 1'b1;
      end
      ST_STMEM: begin
        strobes.memWrite = 1'b1;
        strobes.iorD     = 1'b1;
      end
      ST_REXE: begin
        strobes.aluSrcA = 1'b1;
        strobes.aluOp   = ALUOP_FUNCT;
      end
      ST_RWB: begin
        strobes.regWrite = 1'b1;
        strobes.regDst   = 1'b1;
      end
      ST_OREXE: begin
        strobes.aluSrcA = 1'b1;
        strobes.aluSrcB = SRCB_ZEXT;
        strobes.aluOp   = ALUOP_OR;
      end
      ST_ORWB: strobes.regWrite = 1'b1;
      ST_BREXE: begin
        strobes.aluSrcA     = 1'b1;
        strobes.aluOp       = ALUOP_SUB;
        strobes.pcWriteCond = 1'b1;
        strobes.pcSource    = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mcCtlDrive.sv
module mcCtlDrive
  import mcCtlPkg::*;
(
  input  logic               rstN,
  input  logic               equalFlag,
  input  ctlStrobes_t        strobes,
  output logic               pcWrite,
  output logic               irWrite,
  output logic               memRead,
  output logic               memWrite,
  output logic               iorD,
  output logic               regWrite,
  output logic               regDst,
  output logic               memToReg,
  output logic               aluSrcA,
  output logic [SRCB_W-1:0]  aluSrcB,
  output logic [ALUOP_W-1:0] aluOp,
  output logic               pcSource
);
  // write strobes held quiet while reset is applied (R1)
  assign pcWrite  = rstN & (strobes.pcWriteUncond | (strobes.pcWriteCond & equalFlag));
  assign irWrite  = rstN & strobes.irWrite;
  assign memRead  = rstN & strobes.memRead;
  assign memWrite = rstN & strobes.memWrite;
  assign regWrite = rstN & strobes.regWrite;
  assign iorD     = strobes.iorD;
  assign regDst   = strobes.regDst;
  assign memToReg = strobes.memToReg;
  assign aluSrcA  = strobes.aluSrcA;
  assign aluSrcB  = strobes.aluSrcB;
  assign aluOp    = strobes.aluOp;
  assign pcSource = strobes.pcSource;
endmodule

// File: rtl/mcCtlTop.sv
module mcCtlTop
  import mcCtlPkg::*;
#(
  parameter logic [OPC_W-1:0] OPC_RTYPE = OPC_W'(0),
  parameter logic [OPC_W-1:0] OPC_ORI   = OPC_W'(13),
  parameter logic [OPC_W-1:0] OPC_LOAD  = OPC_W'(35),
  parameter logic [OPC_W-1:0] OPC_STORE = OPC_W'(43),
  parameter logic [OPC_W-1:0] OPC_BEQ   = OPC_W'(4)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [OPC_W-1:0]   opcode,
  input  logic               equalFlag,
  output logic               pcWrite,
  output logic               irWrite,
  output logic               memRead,
  output logic               memWrite,
  output logic               iorD,
  output logic               regWrite,
  output logic               regDst,
  output logic               memToReg,
  output logic               aluSrcA,
  output logic [SRCB_W-1:0]  aluSrcB,
  output logic [ALUOP_W-1:0] aluOp,
  output logic               pcSource
);
  ctlState_e   state;
  ctlStrobes_t strobes;

  mcCtlSequencer #(
    .OPC_RTYPE(OPC_RTYPE), .OPC_ORI(OPC_ORI), .OPC_LOAD(OPC_LOAD),
    .OPC_STORE(OPC_STORE), .OPC_BEQ(OPC_BEQ)
  ) seq_i (
    .clk(clk), .rstN(rstN), .opcode(opcode), .state(state)
  );

  mcCtlStrobeGen gen_i (.state(state), .strobes(strobes));

  mcCtlDrive drv_i (
    .rstN(rstN), .equalFlag(equalFlag), .strobes(strobes),
    .pcWrite(pcWrite), .irWrite(irWrite), .memRead(memRead),
    .memWrite(memWrite), .iorD(iorD), .regWrite(regWrite),
    .regDst(regDst), .memToReg(memToReg), .aluSrcA(aluSrcA),
    .aluSrcB(aluSrcB), .aluOp(aluOp), .pcSource(pcSource)
  );
endmodule

// File: rtl/mcCtlTopChk.sv
module mcCtlTopChk (
  input logic clk,
  input logic rstN,
  input logic equalFlag,
  input logic pcWrite,
  input logic irWrite,
  input logic memRead,
  input logic memWrite,
  input logic regWrite,
  input logic pcSource
);
  // R1: quiet strobes while reset is applied
  always_comb begin
    if (rstN == 1'b0)
      p_reset_quiet_r1: assert (!pcWrite && !irWrite && !memRead && !memWrite && !regWrite);
  end

  // R3: the cycle after fetch writes nothing
  p_decode_no_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    irWrite |=> (!irWrite && !memWrite && !regWrite && !pcWrite));

  // R11: never read and write memory together
  p_mem_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(memRead && memWrite));

  // R4/R5/R6: register write-back is the last step, then fetch
  p_wb_then_fetch_r6: assert property (@(posedge clk) disable iff (!rstN)
    regWrite |=> irWrite);

  // R7: store memory step is the last step, then fetch
  p_store_then_fetch_r7: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |=> irWrite);

  // R8: a PC load outside fetch is a taken branch from the result latch
  p_branch_pc_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pcWrite && !irWrite) |-> (equalFlag && pcSource));
endmodule

bind mcCtlTop mcCtlTopChk chk_i (
  .clk(clk), .rstN(rstN), .equalFlag(equalFlag), .pcWrite(pcWrite),
  .irWrite(irWrite), .memRead(memRead), .memWrite(memWrite),
  .regWrite(regWrite), .pcSource(pcSource)
);

// File: tb/mcCtlTop_tb.sv
module mcCtlTop_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] opcode = 6'd0;
  logic       equalFlag = 1'b0;
  logic       pcWrite, irWrite, memRead, memWrite, iorD, regWrite;
  logic       regDst, memToReg, aluSrcA, pcSource;
  logic [2:0] aluSrcB;
  logic [1:0] aluOp;

  int testCount = 0;
  int failCount = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mcCtlTop dut_i (
    .clk(clk), .rstN(rstN), .opcode(opcode), .equalFlag(equalFlag),
    .pcWrite(pcWrite), .irWrite(irWrite), .memRead(memRead),
    .memWrite(memWrite), .iorD(iorD), .regWrite(regWrite),
    .regDst(regDst), .memToReg(memToReg), .aluSrcA(aluSrcA),
    .aluSrcB(aluSrcB), .aluOp(aluOp), .pcSource(pcSource)
  );

  // observed vector: pcw irw mr mw iord rw rd m2r sa sb[3] op[2] ps
  logic [15:0] obs;
  assign obs = {pcWrite, irWrite, memRead, memWrite, iorD, regWrite, regDst,
                memToReg, aluSrcA, aluSrcB, aluOp, pcSource};

  function automatic logic [15:0] mk(bit pcw, bit irw, bit mr, bit mw, bit iord,
                                     bit rw, bit rd, bit m2r, bit sa,
                                     int sb, int ao, bit ps);
    return {pcw, irw, mr, mw, iord, rw, rd, m2r, sa, 3'(sb), 2'(ao), ps};
  endfunction

  function automatic int expLen(int op);
    case (op)
      0: return 4;
      13: return 4;
      35: return 5;
      43: return 4;
      4: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic string reqOf(int op);
    case (op)
      0: return "R4";
      13: return "R5";
      35: return "R6";
      43: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  // expected strobes per step (step 1 = decode) from the requirements
  function automatic logic [15:0] expVec(int op, bit eq, int step);
    if (step == 1) return mk(0,0,0,0,0,0,0,0,0,3,0,0);
    case (op)
      0:  return (step == 2) ? mk(0,0,0,0,0,0,0,0,1,0,2,0) : mk(0,0,0,0,0,1,1,0,0,0,0,0);
      13: return (step == 2) ? mk(0,0,0,0,0,0,0,0,1,4,3,0) : mk(0,0,0,0,0,1,0,0,0,0,0,0);
      35: begin
        if (step == 2) return mk(0,0,0,0,0,0,0,0,1,2,0,0);
        if (step == 3) return mk(0,0,1,0,1,0,0,0,0,0,0,0);
        return mk(0,0,0,0,0,1,0,1,0,0,0,0);
      end
      43: return (step == 2) ? mk(0,0,0,0,0,0,0,0,1,2,0,0) : mk(0,0,0,1,1,0,0,0,0,0,0,0);
      4:  return mk(eq,0,0,0,0,0,0,0,1,0,1,1);
      default: return 16'hFFFF;
    endcase
  endfunction

  localparam logic [15:0] FETCH_VEC = 16'({1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd1,2'd0,1'b0});

  task automatic chk(string req, string what, int act, int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // called at a negedge inside a fetch cycle; leaves at the next fetch negedge
  task automatic runOne(int op, bit eq, int opAfter);
    int step;
    chk("R2", $sformatf("fetch strobes op %0d", op), int'(obs), int'(FETCH_VEC));
    opcode = 6'(op);
    equalFlag = eq;
    step = 1;
    while (step < 10) begin
      @(posedge clk);
      @(negedge clk);
      if (irWrite) break;
      if (step == 2) opcode = 6'(opAfter);
      chk((step == 1) ? "R3" : reqOf(op),
          $sformatf("op %0d eq %0d step %0d", op, eq, step),
          int'(obs), int'(expVec(op, eq, step)));
      step++;
    end
    chk(reqOf(op), $sformatf("cycle count op %0d eq %0d", op, eq), step, expLen(op));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    equalFlag = 1'b1;
    #1;
    chk("R1", "write strobes in reset",
        int'({pcWrite, irWrite, memRead, memWrite, regWrite}), 0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1", "fetch after reset", int'(irWrite), 1);
    for (int op = 0; op < 64; op++) begin
      for (int e = 0; e < 2; e++) runOne(op, e[0], op);
    end
    // R10: opcode replaced after decode, sequence must stay the same
    runOne(35, 1'b0, 4);
    runOne(4, 1'b1, 35);
    runOne(13, 1'b0, 43);
    runOne(63, 1'b1, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule